// File: doc/BRIEF.md
# Tagged Instruction Word Prefetch Pipeline

This block buffers 16-bit instruction words between a bus prefetch port and an instruction decoder. It keeps two fetched words: the decode stage, shown to the decoder, and a holding stage behind it that catches a word returning from the bus while the decode stage is still occupied. A third register, the execute stage, takes the word the decoder consumed so that residual decode and execution logic can still read it. Every stored word carries a fault bit that marks a word fetched by an abnormally terminated bus cycle. The bit stays with the word through every stage, and the decoder sees it on the same port as the word.

The block issues prefetch requests on a valid/ready handshake, and a request transfers on a cycle where both are high. The request valid may fall without a transfer, for example when the decoder withdraws its consume strobe, because a request carries no data. Responses return in order on a valid-only port with no ready. The block accepts every response, and it avoids overflow by never having more words stored and in flight than it has room for. The decode port is valid/ready: the decoder consumes the decode word by raising `dec_ready_i` while `dec_valid_o` is high. The word is held stable until it is consumed.

On a change of flow the sequencer pulses `flush_i`. All stages empty. Every response still owed to a request issued before the flush is dropped on return. The pipeline then refills in fill mode, which allows two requests in flight at once. Once the first new word is stored, refill passes to streaming mode. Streaming mode keeps at most one request in flight and may issue a request one cycle early when the decoder is consuming that cycle.

Top module: `ifetch_pipe`

## Requirements
- R1: After reset `dec_valid_o` and `exe_valid_o` are 0, and with `flush_i` low `pf_req_valid_o` is 1 (fill mode, empty pipeline).
- R2: A response accepted while no word is stored appears at the decode port on the next cycle, together with its error bit. `dec_valid_o` is 1 exactly when at least one word is stored.
- R3: Words leave the decode port in the order their responses arrived. A word that arrives while the decode stage is occupied waits in the holding stage. The decode word stays stable until it is consumed.
- R4: A consume (`dec_valid_o & dec_ready_i` with `flush_i` low) puts the decode word and its fault bit on the execute port on the next cycle. In the same edge the held word, if any, moves to the decode stage. The execute stage keeps its word until the next consume or flush.
- R5: The fault bit of a word equals the error flag `pf_rsp_err_i` that came with its response, at both the decode port and the execute port.
- R6: A cycle with `flush_i` high empties the decode, holding and execute stages, clearing their valid and fault bits, on the next cycle.
- R7: Responses to requests issued before a flush are discarded when they return. This includes a response arriving in the flush cycle itself. Responses to later requests are kept.
- R8: With H stored words and L live (non-discarded) requests in flight, `pf_req_valid_o` is 1 only if H+L < 2+P, where P is 1 for a consume in streaming mode and 0 otherwise, and fewer than 4 requests of any kind are outstanding. No accepted word is ever lost.
- R9: In streaming mode, with both stages full and nothing in flight, `pf_req_valid_o` is 1 in a cycle where the decoder consumes.
- R10: `pf_req_valid_o` is 0 in any cycle with `flush_i` high. A request is issued only on `pf_req_valid_o & pf_req_ready_i`.
- R11: Fill mode starts at reset and at every flush, and it allows L < 2. It ends when a response is accepted. Streaming mode then allows L < 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Change of flow: empty the pipeline and start a fresh fill |
| pf_req_valid_o | output | 1 | Prefetch request valid |
| pf_req_ready_i | input | 1 | Bus accepts the prefetch request |
| pf_rsp_valid_i | input | 1 | A prefetch response is present (no ready) |
| pf_rsp_data_i | input | 16 | Fetched instruction word |
| pf_rsp_err_i | input | 1 | The bus cycle of this word ended abnormally |
| dec_valid_o | output | 1 | Decode-stage word valid |
| dec_ready_i | input | 1 | Decoder consumes the decode-stage word |
| dec_word_o | output | 16 | Decode-stage word |
| dec_fault_o | output | 1 | Fault bit of the decode-stage word |
| exe_valid_o | output | 1 | Execute-stage word valid |
| exe_word_o | output | 16 | Execute-stage word |
| exe_fault_o | output | 1 | Fault bit of the execute-stage word |

## Verification
The bench predicts the request valid in every cycle from its own count of stored words, live requests and the current mode. A design that ignores in-flight words, skips the consume look-ahead, or allows the wrong number of requests in either mode is caught on the first cycle where the prediction differs. Flushes are placed while several responses are still owed, including one that lands in the flush cycle. A design that keeps a stale word then shows an unexpected word or order at the decode port. Fault bits follow a pattern unrelated to arrival timing, so a design that drops or shifts a fault bit during a park or advance produces a mismatch at the decode port or the execute port.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  parameter int unsigned IPF_WORD_W = 16;

  typedef struct packed {
    logic                  vld;
    logic                  flt;
    logic [IPF_WORD_W-1:0] w;
  } ipf_ent_t;
endpackage

// File: rtl/ipf_stage.sv
module ipf_stage
  import ipf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     ld,
  input  ipf_ent_t d,
  output ipf_ent_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
  end
endmodule

// File: rtl/ipf_credit.sv
module ipf_credit #(
  parameter int unsigned QDEPTH     = 2,
  parameter int unsigned MAX_OUT    = 4,
  parameter int unsigned STREAM_OUT = 1,
  localparam int unsigned HW = $clog2(QDEPTH + 1),
  localparam int unsigned OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [HW-1:0] held_i,
  input  logic          pop_i,
  input  logic          rsp_valid_i,
  input  logic          req_ready_i,
  output logic          req_valid_o,
  output logic          rsp_acc_o,
  output logic [OW-1:0] out_cnt_o,
  output logic [OW-1:0] drop_cnt_o
);
  logic [OW-1:0] out_cnt, drop_cnt;
  logic          fill;
  logic          issue;
  int            live, lim, room;

  always_comb begin
    live = int'(out_cnt) - int'(drop_cnt);
    lim  = fill ? int'(QDEPTH) : int'(STREAM_OUT);
    room = int'(QDEPTH) + ((!fill && pop_i) ? 1 : 0);
    req_valid_o = !flush_i && (int'(out_cnt) < int'(MAX_OUT)) &&
                  (live < lim) && (int'(held_i) + live < room);
  end

  assign issue     = req_valid_o & req_ready_i;
  assign rsp_acc_o = rsp_valid_i && (drop_cnt == '0) && !flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt  <= '0;
      drop_cnt <= '0;
      fill     <= 1'b1;
    end else begin
      out_cnt <= OW'(int'(out_cnt) + int'(issue) - int'(rsp_valid_i));
      if (flush_i)
        drop_cnt <= OW'(int'(out_cnt) - int'(rsp_valid_i));
      else if (rsp_valid_i && drop_cnt != '0)
        drop_cnt <= drop_cnt - 1'b1;
      if (flush_i)        fill <= 1'b1;
      else if (rsp_acc_o) fill <= 1'b0;
    end
  end

  assign out_cnt_o  = out_cnt;
  assign drop_cnt_o = drop_cnt;
endmodule

// File: rtl/ifetch_pipe.sv
module ifetch_pipe
  import ipf_pkg::*;
#(
  parameter int unsigned QDEPTH     = 2,
  parameter int unsigned MAX_OUT    = 4,
  parameter int unsigned STREAM_OUT = 1,
  localparam int unsigned HW = $clog2(QDEPTH + 1),
  localparam int unsigned OW = $clog2(MAX_OUT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  output logic                  pf_req_valid_o,
  input  logic                  pf_req_ready_i,
  input  logic                  pf_rsp_valid_i,
  input  logic [IPF_WORD_W-1:0] pf_rsp_data_i,
  input  logic                  pf_rsp_err_i,
  output logic                  dec_valid_o,
  input  logic                  dec_ready_i,
  output logic [IPF_WORD_W-1:0] dec_word_o,
  output logic                  dec_fault_o,
  output logic                  exe_valid_o,
  output logic [IPF_WORD_W-1:0] exe_word_o,
  output logic                  exe_fault_o
);
  ipf_ent_t      q [QDEPTH];
  ipf_ent_t      nxt [QDEPTH];
  ipf_ent_t      rsp_ent, exe_q;
  logic [HW-1:0] cnt;
  logic          pop, acc;
  logic [OW-1:0] out_cnt, drop_cnt;

  assign rsp_ent = '{vld: 1'b1, flt: pf_rsp_err_i, w: pf_rsp_data_i};
  assign pop     = q[0].vld & dec_ready_i & ~flush_i;

  ipf_credit #(.QDEPTH(QDEPTH), .MAX_OUT(MAX_OUT), .STREAM_OUT(STREAM_OUT)) u_cred (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .held_i     (cnt),
    .pop_i      (pop),
    .rsp_valid_i(pf_rsp_valid_i),
    .req_ready_i(pf_req_ready_i),
    .req_valid_o(pf_req_valid_o),
    .rsp_acc_o  (acc),
    .out_cnt_o  (out_cnt),
    .drop_cnt_o (drop_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (flush_i) cnt <= '0;
    else              cnt <= HW'(int'(cnt) + int'(acc) - int'(pop));
  end

  // slot 0 is the decode stage, higher slots are holding stages
  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    logic     ld;
    ipf_ent_t din;
    if (i + 1 < QDEPTH) begin : g_mid
      assign nxt[i] = q[i+1];
    end else begin : g_last
      assign nxt[i] = '0;
    end
    always_comb begin
      ld  = 1'b0;
      din = '0;
      if (acc && (int'(cnt) - int'(pop)) == i) begin
        ld  = 1'b1;
        din = rsp_ent;
      end else if (pop) begin
        ld  = 1'b1;
        din = nxt[i];
      end
    end
    ipf_stage u_stage (
      .clk(clk), .rst_n(rst_n), .clr(flush_i), .ld(ld), .d(din), .q(q[i])
    );
  end

  ipf_stage u_exe (
    .clk(clk), .rst_n(rst_n), .clr(flush_i), .ld(pop), .d(q[0]), .q(exe_q)
  );

  assign dec_valid_o = q[0].vld;
  assign dec_word_o  = q[0].w;
  assign dec_fault_o = q[0].flt;
  assign exe_valid_o = exe_q.vld;
  assign exe_word_o  = exe_q.w;
  assign exe_fault_o = exe_q.flt;
endmodule

// File: rtl/ipf_chk.sv
module ipf_chk
  import ipf_pkg::*;
#(
  parameter int unsigned QDEPTH  = 2,
  parameter int unsigned MAX_OUT = 4,
  localparam int unsigned HW = $clog2(QDEPTH + 1),
  localparam int unsigned OW = $clog2(MAX_OUT + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  pf_req_valid_o,
  input logic                  pf_rsp_valid_i,
  input logic                  dec_valid_o,
  input logic                  dec_ready_i,
  input logic [IPF_WORD_W-1:0] dec_word_o,
  input logic                  dec_fault_o,
  input logic                  exe_valid_o,
  input logic [IPF_WORD_W-1:0] exe_word_o,
  input logic                  exe_fault_o,
  input logic [HW-1:0]         held,
  input logic [OW-1:0]         out_cnt,
  input logic [OW-1:0]         drop_cnt
);
  logic consume;
  assign consume = dec_valid_o & dec_ready_i & ~flush_i;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!dec_valid_o && !exe_valid_o && !dec_fault_o && !exe_fault_o)); // R6
  AST_NO_REQ_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !pf_req_valid_o); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_rsp_valid_i && drop_cnt == '0 && !flush_i) |-> (int'(held) < int'(QDEPTH) || consume)); // R8
  AST_OUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid_o |-> int'(out_cnt) < int'(MAX_OUT)); // R8
  AST_EXE_TAKES_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (exe_valid_o && exe_word_o == $past(dec_word_o) && exe_fault_o == $past(dec_fault_o))); // R4
  AST_DEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_ready_i && !flush_i) |=> (dec_valid_o && $stable(dec_word_o) && $stable(dec_fault_o))); // R3
  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt <= out_cnt); // R7
endmodule

bind ifetch_pipe ipf_chk #(.QDEPTH(QDEPTH), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .pf_req_valid_o(pf_req_valid_o),
  .pf_rsp_valid_i(pf_rsp_valid_i), .dec_valid_o(dec_valid_o), .dec_ready_i(dec_ready_i),
  .dec_word_o(dec_word_o), .dec_fault_o(dec_fault_o), .exe_valid_o(exe_valid_o),
  .exe_word_o(exe_word_o), .exe_fault_o(exe_fault_o), .held(cnt),
  .out_cnt(out_cnt), .drop_cnt(drop_cnt)
);

// File: tb/sim_ifetch_pipe.sv
`timescale 1ns/1ps
module sim_ifetch_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        pf_req_valid_o, pf_req_ready_i = 1'b0;
  logic        pf_rsp_valid_i = 1'b0;
  logic [15:0] pf_rsp_data_i = '0;
  logic        pf_rsp_err_i = 1'b0;
  logic        dec_valid_o, dec_ready_i = 1'b0;
  logic [15:0] dec_word_o, exe_word_o;
  logic        dec_fault_o, exe_valid_o, exe_fault_o;

  always #4 clk = ~clk;

  ifetch_pipe u0 (.*);

  typedef struct { logic [15:0] w; bit e; int ep; int due; } bus_t;
  typedef struct { logic [15:0] w; bit e; } exp_t;

  bus_t bus_q[$];
  exp_t exp_q[$];
  bus_t cur;
  exp_t exe_exp;
  bit   exe_exp_v = 0;
  int   checks = 0, fails = 0;
  int   cyc = 0, epoch = 0, seq = 0, lat = 1, last_due = 0;
  bit   fill = 1, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit fl, input bit dr, input bit rr);
    int  live, pop, lim, room;
    bit  pred, acc;
    exp_t x;
    @(negedge clk);
    cyc++;
    // state checks on the last edge's results
    chk(dec_valid_o == (exp_q.size() > 0), "R2 dec_valid", dec_valid_o, exp_q.size() > 0);
    chk(exe_valid_o == exe_exp_v, "R4 R6 exe_valid", exe_valid_o, exe_exp_v);
    if (exe_exp_v) begin
      chk(exe_word_o == exe_exp.w, "R4 exe_word", exe_word_o, exe_exp.w);
      chk(exe_fault_o == exe_exp.e, "R5 exe_fault", exe_fault_o, exe_exp.e);
    end
    // drive
    flush_i = fl; dec_ready_i = dr; pf_req_ready_i = rr;
    pf_rsp_valid_i = 1'b0;
    if (bus_q.size() > 0 && bus_q[0].due <= cyc) begin
      cur = bus_q.pop_front();
      pf_rsp_valid_i = 1'b1; pf_rsp_data_i = cur.w; pf_rsp_err_i = cur.e;
    end
    #1;
    // predict the request from the requirements
    live = 0;
    foreach (bus_q[k]) if (bus_q[k].ep == epoch) live++;
    if (pf_rsp_valid_i && cur.ep == epoch) live++;
    pop  = (exp_q.size() > 0 && dr && !fl) ? 1 : 0;
    lim  = fill ? 2 : 1;
    room = 2 + ((!fill && pop == 1) ? 1 : 0);
    pred = !fl && (bus_q.size() + int'(pf_rsp_valid_i) < 4) && (live < lim) &&
           (exp_q.size() + live < room);
    chk(pf_req_valid_o == pred, "R8 R9 R10 R11 pf_req_valid", pf_req_valid_o, pred);
    // scoreboard monitor: pop and compare
    if (pop == 1) begin
      x = exp_q.pop_front();
      chk(dec_word_o == x.w, "R3 dec_word order", dec_word_o, x.w);
      chk(dec_fault_o == x.e, "R5 dec_fault", dec_fault_o, x.e);
      exe_exp = x; exe_exp_v = 1;
    end
    acc = pf_rsp_valid_i && cur.ep == epoch && !fl;
    if (fl) begin
      exp_q.delete(); exe_exp_v = 0; epoch++; fill = 1;
    end
    if (acc) begin
      chk(exp_q.size() < 2, "R8 overflow", exp_q.size(), 1);
      x.w = cur.w; x.e = cur.e;
      exp_q.push_back(x);
      fill = 0;
    end
    // driver side of the bus: record an issued request
    if (pf_req_valid_o && rr) begin
      bus_t b;
      b.w = 16'hA000 + 16'(seq); b.e = (seq % 5 == 3); b.ep = epoch;
      b.due = (cyc + lat > last_due + 1) ? cyc + lat : last_due + 1;
      last_due = b.due;
      seq++;
      bus_q.push_back(b);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid_o == 0, "R1 dec_valid", dec_valid_o, 0);
    chk(exe_valid_o == 0, "R1 exe_valid", exe_valid_o, 0);
    chk(pf_req_valid_o == 1, "R1 pf_req_valid", pf_req_valid_o, 1);
    // fill until full, decoder idle (R2, R3, R8, R11)
    lat = 1;
    repeat (8) step(0, 0, 1);
    // full and nothing in flight: consume lets a request through (R9)
    step(0, 1, 1);
    repeat (6) step(0, 1, 1);
    // mixed back-pressure and latency
    for (int n = 0; n < 60; n++) begin
      lat = 1 + ($urandom % 3);
      step(0, ($urandom % 3) != 0, ($urandom % 4) != 0);
    end
    // flush with several responses owed (R6, R7)
    lat = 3;
    repeat (3) step(0, 0, 1);
    step(1, 1, 1);
    repeat (12) step(0, 1, 1);
    // flush landing on a returning response (R7)
    lat = 2;
    step(0, 0, 1);
    step(0, 0, 1);
    step(1, 0, 1);
    repeat (10) step(0, 0, 1);
    // long mixed run with occasional flushes
    for (int n = 0; n < 300; n++) begin
      lat = 1 + ($urandom % 3);
      step(($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0);
    end
    repeat (10) step(0, 1, 1);
    finish_run();
  end
endmodule